// File: doc/BRIEF.md
# Two-Threshold 3x3 Cluster Finder

This block screens a raster-ordered stream of 8-bit pixel values for clusters. Each accepted pixel is turned into a 2-bit code by two programmable thresholds. A lower one marks weak signal and a higher one marks a seed. The codes pass through a line delay of just over two rows, which exposes a 3x3 window of codes around a centre pixel that trails the input by one row plus one pixel.

When the centre of that window is a seed, the block emits one record. The record holds the centre's linear frame address and an 8-bit mask of the neighbours whose code is not below the lower threshold. No amplitudes are kept. Records leave through a single registered valid/ready stage.

The pixel stream never stalls. If the output stage is still occupied when a new record is formed, that record is discarded. A sticky overflow flag and a saturating drop counter then report the loss.

Top module: `cluster_finder_3x3`

## Requirements
- R1: Each accepted pixel is coded against both thresholds, with both comparisons inclusive. The code is 00 when the value is below `thr_low`. It is 01 when the value is at or above `thr_low` and below `thr_high`. It is 11 when the value is at or above `thr_high`.
- R2: Exactly one record is emitted for every frame pixel whose code is 11, in raster order. `out_addr` equals row*COLS+col. The address of the first pixel after reset is 0, and addressing wraps to 0 after COLS*ROWS pixels.
- R3: `out_mask` bit b is set when that neighbour's code is not 00. The bits follow row-major order with the centre skipped: bit0 up-left, bit1 up, bit2 up-right, bit3 left, bit4 right, bit5 down-left, bit6 down, bit7 down-right.
- R4: Neighbours outside the frame count as 00. On row 0, bits 0..2 are clear; on the last row, bits 5..7. On column 0, bits 0, 3 and 5 are clear; on the last column, bits 2, 4 and 7. No neighbour is taken from the adjacent row's far end.
- R5: The record for pixel k appears on `out_valid` after the second rising edge following the edge that samples pixel k+COLS+1.
- R6: Cycles with `in_valid` low neither advance addresses nor change the window; they only delay the stream.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_mask` hold their values.
- R8: A record formed while the output stage holds an unaccepted record is dropped. The drop sets `overflow`, which stays set until reset, and increments `drop_count`, which saturates at its all-ones value.
- R9: After reset, `out_valid` and `overflow` are 0 and `drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_pix | input | PIX_W (8) | Pixel value, raster order |
| thr_low | input | PIX_W (8) | Neighbour threshold (inclusive) |
| thr_high | input | PIX_W (8) | Seed threshold (inclusive) |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts the record |
| out_addr | output | ADDR_W (18) | Linear address of the seed pixel |
| out_mask | output | 8 | Neighbours at or above the low threshold |
| overflow | output | 1 | Sticky: a record was dropped |
| drop_count | output | CNT_W (16) | Saturating count of dropped records |

## Verification
An isolated seed with a hand-picked neighbourhood fixes the exact cycle of the record and each mask bit position. A frame filled with weak background and seeds on every corner and edge separates correct edge masking from wrap-around between rows. Values one below and exactly at each threshold pin down inclusivity. A pseudo-random frame with idle gaps, and a frame that follows an empty one, test stream pausing and address wrap against a model of the whole frame. Holding `out_ready` low across several seeds separates held, dropped and saturated-count behaviour.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic [1:0] {
    CODE_NONE = 2'b00,
    CODE_LOW  = 2'b01,
    CODE_HIGH = 2'b11
  } pix_code_e;
endpackage

// File: rtl/cf_classify.sv
module cf_classify
  import cf_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [PIX_W-1:0] thr_low,
  input  logic [PIX_W-1:0] thr_high,
  output logic             s_valid,
  output pix_code_e        s_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_code  <= CODE_NONE;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        if (in_pix >= thr_high)     s_code <= CODE_HIGH;
        else if (in_pix >= thr_low) s_code <= CODE_LOW;
        else                        s_code <= CODE_NONE;
      end
    end
  end

  // R1
  seed_code_chk: assert property (@(posedge clk) disable iff (rst)
    s_valid && s_code == CODE_HIGH |-> $past(in_pix) >= $past(thr_high));
  // R1
  quiet_code_chk: assert property (@(posedge clk) disable iff (rst)
    s_valid && s_code == CODE_NONE |-> $past(in_pix) < $past(thr_low));
endmodule

// File: rtl/cf_line_window.sv
module cf_line_window
  import cf_pkg::*;
#(
  parameter int COLS = 320
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        s_valid,
  input  pix_code_e   s_code,
  output logic        win_valid,
  output logic [17:0] win_codes
);
  localparam int DEPTH  = 2 * COLS + 3;
  localparam int PRIME  = COLS + 1;
  localparam int FILL_W = $clog2(PRIME + 1);

  pix_code_e         dly [DEPTH];
  logic [FILL_W-1:0] fill;

  // plain shift chain, no reset: stale entries are hidden by edge masking
  always_ff @(posedge clk) begin
    if (s_valid) begin
      dly[0] <= s_code;
      for (int i = 1; i < DEPTH; i++) dly[i] <= dly[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      win_valid <= 1'b0;
    end else begin
      win_valid <= s_valid && (fill == FILL_W'(PRIME));
      if (s_valid && fill != FILL_W'(PRIME)) fill <= fill + 1'b1;
    end
  end

  // window position p = 3*r + c, r = 0 is the upper row, c = 0 the left column
  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      assign win_codes[2*(3*r+c) +: 2] = dly[(2-r)*COLS + (2-c)];
    end
  end

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> !win_valid);
endmodule

// File: rtl/cf_addr_track.sv
module cf_addr_track #(
  parameter int COLS   = 320,
  parameter int ROWS   = 640,
  parameter int ADDR_W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  output logic [$clog2(COLS)-1:0]  col,
  output logic [$clog2(ROWS)-1:0]  row,
  output logic [ADDR_W-1:0]        addr
);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int FRAME = COLS * ROWS;

  always_ff @(posedge clk) begin
    if (rst) begin
      col  <= '0;
      row  <= '0;
      addr <= '0;
    end else if (adv) begin
      if (col == COL_W'(COLS - 1)) begin
        col <= '0;
        row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
      addr <= (addr == ADDR_W'(FRAME - 1)) ? '0 : addr + 1'b1;
    end
  end

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    addr <= ADDR_W'(FRAME - 1));
  // R6
  addr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(addr));
endmodule

// File: rtl/cf_record_out.sv
module cf_record_out
  import cf_pkg::*;
#(
  parameter int COLS   = 320,
  parameter int ROWS   = 640,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    win_valid,
  input  logic [17:0]             win_codes,
  input  logic [$clog2(COLS)-1:0] col,
  input  logic [$clog2(ROWS)-1:0] row,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [7:0]              out_mask,
  output logic                    overflow,
  output logic [CNT_W-1:0]        drop_count
);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  logic       at_top, at_bot, at_lft, at_rgt;
  logic [7:0] nb;
  logic       seed, slot_free;

  assign at_top = (row == '0);
  assign at_bot = (row == ROW_W'(ROWS - 1));
  assign at_lft = (col == '0);
  assign at_rgt = (col == COL_W'(COLS - 1));

  for (genvar p = 0; p < 9; p++) begin : g_nb
    if (p != 4) begin : g_use
      localparam int B  = (p < 4) ? p : p - 1;
      localparam int WR = p / 3;
      localparam int WC = p % 3;
      assign nb[B] = (win_codes[2*p +: 2] != CODE_NONE)
                   && !(WR == 0 && at_top) && !(WR == 2 && at_bot)
                   && !(WC == 0 && at_lft) && !(WC == 2 && at_rgt);
    end
  end

  assign seed      = win_valid && (win_codes[9:8] == CODE_HIGH);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_mask   <= '0;
      overflow   <= 1'b0;
      drop_count <= '0;
    end else begin
      if (seed && slot_free) begin
        out_valid <= 1'b1;
        out_addr  <= addr;
        out_mask  <= nb;
      end else begin
        if (out_ready) out_valid <= 1'b0;
        if (seed) begin
          overflow <= 1'b1;
          if (drop_count != '1) drop_count <= drop_count + 1'b1;
        end
      end
    end
  end

  // R7
  hold_rec_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_mask));
  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    drop_count != $past(drop_count) |-> drop_count == $past(drop_count) + 1'b1 && overflow);
  // R4
  top_edge_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_addr < ADDR_W'(COLS) |-> out_mask[2:0] == 3'b000);
  // R4
  left_edge_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_addr % ADDR_W'(COLS)) == '0 |-> (out_mask & 8'b0010_1001) == 8'h00);
endmodule

// File: rtl/cluster_finder_3x3.sv
module cluster_finder_3x3
  import cf_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COLS   = 320,
  parameter int ROWS   = 640,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [PIX_W-1:0]  thr_low,
  input  logic [PIX_W-1:0]  thr_high,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [7:0]        out_mask,
  output logic              overflow,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  logic              s_valid;
  pix_code_e         s_code;
  logic              win_valid;
  logic [17:0]       win_codes;
  logic [COL_W-1:0]  c_col;
  logic [ROW_W-1:0]  c_row;
  logic [ADDR_W-1:0] c_addr;

  cf_classify #(.PIX_W(PIX_W)) u_classify (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
    .thr_low(thr_low), .thr_high(thr_high),
    .s_valid(s_valid), .s_code(s_code)
  );

  cf_line_window #(.COLS(COLS)) u_window (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_code(s_code),
    .win_valid(win_valid), .win_codes(win_codes)
  );

  cf_addr_track #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .adv(win_valid),
    .col(c_col), .row(c_row), .addr(c_addr)
  );

  cf_record_out #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_codes(win_codes),
    .col(c_col), .row(c_row), .addr(c_addr), .out_ready(out_ready),
    .out_valid(out_valid), .out_addr(out_addr), .out_mask(out_mask),
    .overflow(overflow), .drop_count(drop_count)
  );
endmodule

// File: tb/tb_cluster_finder_3x3.sv
module tb_cluster_finder_3x3;
  localparam int CLK_PERIOD = 10;
  localparam int COLS  = 16;
  localparam int ROWS  = 8;
  localparam int NPIX  = COLS * ROWS;
  localparam int AW    = 18;
  localparam int CW    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_pix = '0;
  logic [7:0]    thr_low = '0;
  logic [7:0]    thr_high = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [7:0]    out_mask;
  logic          overflow;
  logic [CW-1:0] drop_count;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b1;
  logic [7:0] img [NPIX];
  logic [AW+7:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_finder_3x3 #(.PIX_W(8), .COLS(COLS), .ROWS(ROWS), .ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
    .thr_low(thr_low), .thr_high(thr_high), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_mask(out_mask),
    .overflow(overflow), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && mon_en && out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected record", {out_addr, out_mask}, 0);
      else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        check({out_addr, out_mask} == e, "R2/R3 record", {out_addr, out_mask}, e);
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; mon_en = 1'b1;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] p);
    in_valid = 1'b1; in_pix = p;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clear_img(input logic [7:0] v);
    for (int i = 0; i < NPIX; i++) img[i] = v;
  endtask

  // model: seed at >= hi, neighbour at >= lo, row-major bits with centre skipped
  task automatic build_expected(input int lo, input int hi);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (int'(img[r*COLS+c]) >= hi) begin
          logic [7:0] m;
          int b;
          m = '0; b = 0;
          for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
              if (!(dr == 0 && dc == 0)) begin
                int rr, cc;
                rr = r + dr; cc = c + dc;
                if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS && int'(img[rr*COLS+cc]) >= lo)
                  m[b] = 1'b1;
                b++;
              end
            end
          end
          exp_q.push_back({AW'(r*COLS+c), m});
        end
      end
    end
  endtask

  task automatic stream(input int from, input int gap_every);
    for (int i = from; i < NPIX; i++) begin
      push(img[i]);
      if (gap_every > 0 && (i % gap_every) == 0) idle(2);
    end
    for (int i = 0; i < NPIX; i++) push(8'd0);
    idle(6);
  endtask

  task automatic t_reset();
    do_reset();
    idle(1);
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(overflow == 1'b0, "R9 overflow", overflow, 0);
    check(drop_count == '0, "R9 drop_count", drop_count, 0);
  endtask

  task automatic t_latency();
    int k;
    do_reset();
    thr_low = 8'd20; thr_high = 8'd100;
    clear_img(8'd0);
    k = 3*COLS + 5;
    img[k] = 8'd150;
    img[k-COLS-1] = 8'd20;   // up-left, bit0
    img[k-COLS+1] = 8'd19;   // below low
    img[k+1]      = 8'd99;   // right, bit4
    img[k+COLS]   = 8'd50;   // down, bit6
    build_expected(20, 100);
    check(exp_q[0] == {AW'(k), 8'h51}, "R3 model mask", exp_q[0], {AW'(k), 8'h51});
    for (int i = 0; i <= k + COLS + 1; i++) push(img[i]);
    @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R5 not yet", out_valid, 0);
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b1, "R5 record present", out_valid, 1);
    #1;
    stream(k + COLS + 2, 0);
    check(exp_q.size() == 0, "R2 all records seen", exp_q.size(), 0);
  endtask

  task automatic t_edges();
    do_reset();
    thr_low = 8'd20; thr_high = 8'd100;
    clear_img(8'd20);
    img[0] = 8'd200; img[COLS-1] = 8'd200;
    img[(ROWS-1)*COLS] = 8'd200; img[NPIX-1] = 8'd200;
    img[3*COLS] = 8'd200; img[3*COLS+COLS-1] = 8'd200;
    img[6] = 8'd200; img[(ROWS-1)*COLS+9] = 8'd200;
    build_expected(20, 100);
    // R4 corner (0,0) keeps only right, down, down-right
    check(exp_q[0] == {AW'(0), 8'hD0}, "R4 model corner", exp_q[0], {AW'(0), 8'hD0});
    stream(0, 0);
    check(exp_q.size() == 0, "R4 edge records seen", exp_q.size(), 0);
  endtask

  task automatic t_thresh();
    do_reset();
    thr_low = 8'd50; thr_high = 8'd120;
    clear_img(8'd0);
    img[2*COLS+2] = 8'd120;
    img[1*COLS+1] = 8'd50;  img[1*COLS+2] = 8'd49;
    img[2*COLS+3] = 8'd119; img[3*COLS+3] = 8'd51;
    img[5*COLS+8] = 8'd119;
    img[5*COLS+12] = 8'd121;
    build_expected(50, 120);
    check(exp_q.size() == 2, "R1 seed count model", exp_q.size(), 2);
    stream(0, 0);
    check(exp_q.size() == 0, "R1 threshold records seen", exp_q.size(), 0);
  endtask

  task automatic t_random();
    logic [31:0] s;
    do_reset();
    thr_low = 8'd100; thr_high = 8'd200;
    s = 32'h1234_5678;
    for (int i = 0; i < NPIX; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      img[i] = s[23:16];
    end
    build_expected(100, 200);
    stream(0, 5);
    check(exp_q.size() == 0, "R6 gapped stream records seen", exp_q.size(), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    thr_low = 8'd10; thr_high = 8'd90;
    for (int i = 0; i < NPIX; i++) push(8'd0);
    clear_img(8'd0);
    img[COLS+1] = 8'd90; img[2*COLS+2] = 8'd10;
    build_expected(10, 90);
    stream(0, 0);
    check(exp_q.size() == 0, "R2 wrapped address records seen", exp_q.size(), 0);
  endtask

  task automatic t_backpressure();
    logic [AW-1:0] a0;
    do_reset();
    mon_en = 1'b0;
    out_ready = 1'b0;
    thr_low = 8'd20; thr_high = 8'd100;
    clear_img(8'd0);
    img[2*COLS+2] = 8'd150; img[2*COLS+5] = 8'd150; img[2*COLS+8] = 8'd150;
    img[2*COLS+11] = 8'd150; img[4*COLS+4] = 8'd150;
    a0 = AW'(2*COLS+2);
    stream(0, 0);
    check(out_valid == 1'b1, "R7 first record held", out_valid, 1);
    check(out_addr == a0, "R7 held address", out_addr, a0);
    check(out_mask == 8'h00, "R7 held mask", out_mask, 0);
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    check(drop_count == 2'd3, "R8 drop count saturates", drop_count, 3);
    idle(3);
    check(out_valid == 1'b1 && out_addr == a0, "R7 still held", out_addr, a0);
    out_ready = 1'b1;
    idle(1);
    check(out_valid == 1'b0, "R7 released after accept", out_valid, 0);
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    mon_en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_latency();
    t_edges();
    t_thresh();
    t_random();
    t_wrap();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule